// File: doc/BRIEF.md
# Horizontal Sync Glitch Lockout Filter

This block sits on the raw horizontal sync input of a video capture front end. It removes spurious sync transitions before they reach the line-locking logic. The input is sampled on the reference clock through a synchronizer. When masking is on, each accepted leading edge starts a lockout interval of twice the programmed width, counted in reference clocks. While that interval runs, no new leading edge is taken. The cleaned pulse ends on the first trailing edge after acceptance, and later edges in the interval are dropped. Copy-protection pseudo-syncs and short glitches near the true sync therefore leave the output untouched.

The block also reports the length of each cleaned pulse in reference clocks. Software can read this value to choose the width setting. A usable minimum is the measured pulse length plus the line-length tolerance. A setting above half the line length is not valid, and the user must keep the setting below that limit. When masking is off, the width setting has no effect and the synchronized input goes straight to the output. All syncs are active high.

Top module: `hsync_mask_gate`

## Requirements
- R1: While reset is asserted and at release, `hs_clean` is 0 and `hs_width` is 0.
- R2: With masking idle, a rising edge on `hs_raw` that is first sampled at clock edge k appears on `hs_clean` after clock edge k+2. The path is a two-stage synchronizer plus one output register.
- R3: With `mask_en` = 0, `hs_clean` equals `hs_raw` delayed by three clock edges, whatever the value of `mask_en_width`.
- R4: With `mask_en` = 1, an accepted leading edge starts a lockout of 2 × `mask_en_width` clocks. No leading edge that reaches the output register during that lockout sets `hs_clean`.
- R5: After an accepted leading edge, `hs_clean` falls on the first trailing edge of the synchronized input. Any further trailing or leading edges inside the lockout have no effect on `hs_clean`.
- R6: With `mask_en` = 1 and `mask_en_width` = 0, no lockout exists and `hs_clean` follows the input as in R3.
- R7: A leading edge that reaches the output register on the first clock after the lockout has run out is accepted.
- R8: `hs_width` is loaded with the number of clocks for which `hs_clean` was high. The load happens on the same clock edge on which `hs_clean` falls, so it updates once per accepted line.
- R9: The measured width saturates at 255 for pulses of 255 clocks or longer.
- R10: `hs_width` changes only on a clock edge where `hs_clean` falls, and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hs_raw | input | 1 | Unfiltered horizontal sync, active high, asynchronous |
| mask_en | input | 1 | 1 enables the lockout filter, 0 passes the sync through |
| mask_en_width | input | 8 | Lockout setting; the lockout lasts twice this many clocks |
| hs_clean | output | 1 | Filtered horizontal sync, active high |
| hs_width | output | 8 | Length of the last cleaned pulse in clocks, saturating |

## Verification
The assertions watch four things on every clock: the quiet outputs during reset, the pass-through relation when masking is off, the absence of any new output pulse while the lockout counter is running, and the rule that the width readout changes only on a falling output. Other behaviours need the bench's cycle-accurate model driven with real pulse trains. These are the exact three-clock latency, the placement of the lockout boundary one clock either side, the way glitches inside a pulse end it early, the saturation at 255, and mixed lines carrying pseudo-syncs under random settings.

// File: rtl/hsm_pkg.sv
package hsm_pkg;
  // Synchronized sync level together with its one-clock edge strobes.
  typedef struct packed {
    logic level;
    logic rise;
    logic fall;
  } sync_evt_t;
endpackage

// File: rtl/hsm_rst_sync.sv
module hsm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) pipe_q <= '0;
    else         pipe_q <= pipe_d;
  end

  assign rst_n_sync = pipe_q[STAGES-1];
endmodule

// File: rtl/hsm_edge_sync.sv
module hsm_edge_sync
  import hsm_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      din,
  output sync_evt_t evt
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              last_q;
  logic              last_d;

  assign chain_d[0] = din;
  for (genvar i = 1; i < STAGES; i++) begin : g_chain
    assign chain_d[i] = chain_q[i-1];
  end

  always_comb begin
    last_d = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      last_q  <= last_d;
    end
  end

  always_comb begin
    evt.level = chain_q[STAGES-1];
    evt.rise  = chain_q[STAGES-1] & ~last_q;
    evt.fall  = ~chain_q[STAGES-1] & last_q;
  end
endmodule

// File: rtl/hsm_window.sv
module hsm_window
  import hsm_pkg::*;
#(
  parameter int SET_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SET_W-1:0] width_set,
  input  sync_evt_t        evt,
  output logic             hs_out,
  output logic             accept,
  output logic             rel,
  output logic             busy
);
  localparam int CNT_W = SET_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             act_q, act_d;
  logic [CNT_W-1:0] win_len;

  assign win_len = {width_set, 1'b0};

  always_comb begin
    cnt_d  = cnt_q;
    act_d  = act_q;
    accept = 1'b0;
    rel    = 1'b0;
    if (!en) begin
      act_d  = evt.level;
      cnt_d  = '0;
      accept = evt.rise;
      rel    = evt.fall & act_q;
    end else begin
      cnt_d = (cnt_q != '0) ? cnt_q - 1'b1 : '0;
      if (evt.rise && (cnt_q == '0)) begin
        act_d  = 1'b1;
        cnt_d  = win_len;
        accept = 1'b1;
      end else if (evt.fall && act_q) begin
        act_d = 1'b0;
        rel   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign hs_out = act_q;
  assign busy   = (cnt_q != '0);
endmodule

// File: rtl/hsm_width_meas.sv
module hsm_width_meas #(
  parameter int MEAS_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              rel,
  output logic [MEAS_W-1:0] width_o
);
  localparam logic [MEAS_W-1:0] SAT = '1;

  logic [MEAS_W-1:0] cnt_q, cnt_d;
  logic [MEAS_W-1:0] wid_q, wid_d;
  logic              busy_q, busy_d;
  logic              cnt_en;

  assign cnt_en = busy_q && (cnt_q != SAT);

  always_comb begin
    cnt_d  = cnt_q;
    wid_d  = wid_q;
    busy_d = busy_q;
    if (rel) begin
      wid_d  = cnt_q;
      busy_d = 1'b0;
    end else if (accept) begin
      cnt_d  = {{(MEAS_W-1){1'b0}}, 1'b1};
      busy_d = 1'b1;
    end else if (cnt_en) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wid_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      wid_q  <= wid_d;
      busy_q <= busy_d;
    end
  end

  assign width_o = wid_q;
endmodule

// File: rtl/hsync_mask_gate.sv
module hsync_mask_gate
  import hsm_pkg::*;
#(
  parameter int SET_W       = 8,
  parameter int MEAS_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              hs_raw,
  input  logic              mask_en,
  input  logic [SET_W-1:0]  mask_en_width,
  output logic              hs_clean,
  output logic [MEAS_W-1:0] hs_width
);
  logic      rst_n_int;
  sync_evt_t evt;
  logic      accept;
  logic      rel;
  logic      win_busy;

  hsm_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk_ref),
    .arst_n     (rst_n),
    .rst_n_sync (rst_n_int)
  );

  hsm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk_ref),
    .rst_n (rst_n_int),
    .din   (hs_raw),
    .evt   (evt)
  );

  hsm_window #(.SET_W(SET_W)) u_win (
    .clk       (clk_ref),
    .rst_n     (rst_n_int),
    .en        (mask_en),
    .width_set (mask_en_width),
    .evt       (evt),
    .hs_out    (hs_clean),
    .accept    (accept),
    .rel       (rel),
    .busy      (win_busy)
  );

  hsm_width_meas #(.MEAS_W(MEAS_W)) u_meas (
    .clk     (clk_ref),
    .rst_n   (rst_n_int),
    .accept  (accept),
    .rel     (rel),
    .width_o (hs_width)
  );
endmodule

// File: rtl/hsync_mask_gate_chk.sv
module hsync_mask_gate_chk #(
  parameter int MEAS_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mask_en,
  input logic              lvl,
  input logic              win_busy,
  input logic              hs_clean,
  input logic [MEAS_W-1:0] hs_width
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!hs_clean && (hs_width == '0)));

  a_r3_bypass_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_en |=> (hs_clean == $past(lvl)));

  a_r4_no_new_pulse_in_lockout: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_en && win_busy) |=> !$rose(hs_clean));

  a_r10_width_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hs_width) |-> $fell(hs_clean));
endmodule

bind hsync_mask_gate hsync_mask_gate_chk #(.MEAS_W(MEAS_W)) u_chk (
  .clk      (clk_ref),
  .rst_n    (rst_n),
  .mask_en  (mask_en),
  .lvl      (evt.level),
  .win_busy (win_busy),
  .hs_clean (hs_clean),
  .hs_width (hs_width)
);

// File: tb/hsync_mask_gate_test.sv
module hsync_mask_gate_test;
  logic       clk_ref = 1'b0;
  logic       rst_n   = 1'b1;
  logic       hs_raw  = 1'b0;
  logic       mask_en = 1'b0;
  logic [7:0] mask_en_width = 8'd0;
  logic       hs_clean;
  logic [7:0] hs_width;

  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;
  string       cur_req = "R1";
  bit          run_cmp = 1'b0;

  // model state
  bit m1, m2, mp, mq;
  int mwin, mcnt, mwidth;
  bit mbusy;

  hsync_mask_gate uut (
    .clk_ref       (clk_ref),
    .rst_n         (rst_n),
    .hs_raw        (hs_raw),
    .mask_en       (mask_en),
    .mask_en_width (mask_en_width),
    .hs_clean      (hs_clean),
    .hs_width      (hs_width)
  );

  always #10 clk_ref = ~clk_ref; // 50 MHz

  // Expected behaviour computed from the requirements.
  always @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      m1 = 0; m2 = 0; mp = 0; mq = 0;
      mwin = 0; mcnt = 0; mwidth = 0; mbusy = 0;
    end else begin
      bit up, dn, nq, acc, rl;
      int nwin;
      up = m2 && !mp;
      dn = !m2 && mp;
      nq = mq; acc = 0; rl = 0; nwin = 0;
      if (!mask_en) begin
        nq = m2; acc = up; rl = dn && mq;
      end else begin
        nwin = (mwin > 0) ? mwin - 1 : 0;
        if (up && mwin == 0) begin
          nq = 1; acc = 1; nwin = 2 * int'(mask_en_width);
        end else if (dn && mq) begin
          nq = 0; rl = 1;
        end
      end
      if (rl) begin mwidth = mcnt; mbusy = 0; end
      else if (acc) begin mcnt = 1; mbusy = 1; end
      else if (mbusy && mcnt < 255) mcnt = mcnt + 1;
      mq = nq; mwin = nwin;
      mp = m2; m2 = m1; m1 = hs_raw;
    end
  end

  task automatic check(string req, int act, int exp, string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk_ref) begin
    if (run_cmp) begin
      check(cur_req, int'(hs_clean), int'(mq), "hs_clean");
      check(cur_req, int'(hs_width), mwidth, "hs_width");
    end
  end

  task automatic hold(bit v, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_ref);
      hs_raw = v;
    end
  endtask

  task automatic random_toggles(int n, int maxrun);
    int left = n;
    while (left > 0) begin
      int r = 1 + ($urandom % maxrun);
      hold(~hs_raw, r);
      left -= r;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0417));
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk_ref);
    // R1: reset values
    check("R1", int'(hs_clean), 0, "hs_clean in reset");
    check("R1", int'(hs_width), 0, "hs_width in reset");
    @(posedge clk_ref); #3 rst_n = 1'b1;
    repeat (4) @(negedge clk_ref);
    check("R1", int'(hs_clean), 0, "hs_clean after release");
    check("R1", int'(hs_width), 0, "hs_width after release");
    run_cmp = 1'b1;

    // R2: three-edge latency, checked explicitly
    cur_req = "R2"; mask_en = 1; mask_en_width = 8'd3;
    @(negedge clk_ref); hs_raw = 1;
    @(negedge clk_ref); check("R2", int'(hs_clean), 0, "after 1 edge");
    @(negedge clk_ref); check("R2", int'(hs_clean), 0, "after 2 edges");
    @(negedge clk_ref); check("R2", int'(hs_clean), 1, "after 3 edges");
    hold(1, 5); hold(0, 30);

    // R3: pass-through when masking is off, width setting ignored
    cur_req = "R3"; mask_en = 0; mask_en_width = 8'd40;
    random_toggles(600, 6);
    hold(0, 10);
    // switch mode in the middle of a line
    mask_en = 1; mask_en_width = 8'd8;
    hold(1, 4); hold(0, 2); mask_en = 0; hold(1, 5); hold(0, 20);

    // R4 and R5: glitches and pseudo-syncs inside the lockout
    cur_req = "R4"; mask_en = 1; mask_en_width = 8'd6;
    hold(1, 4); hold(0, 1); hold(1, 2); hold(0, 2); hold(1, 2); hold(0, 40);
    cur_req = "R5";
    hold(1, 3); hold(0, 3); hold(1, 3); hold(0, 40);

    // R7: leading edge placed around the end of the lockout
    cur_req = "R7";
    for (int gap = 8; gap <= 14; gap++) begin
      hold(1, 2); hold(0, gap); hold(1, 3); hold(0, 40);
    end

    // R6: zero setting, no lockout
    cur_req = "R6"; mask_en = 1; mask_en_width = 8'd0;
    random_toggles(500, 5);
    hold(0, 10);

    // R8: measured width across pulse lengths
    cur_req = "R8"; mask_en_width = 8'd2;
    for (int k = 0; k < 30; k++) begin
      hold(1, 1 + ($urandom % 40)); hold(0, 50);
    end

    // R9: saturation
    cur_req = "R9";
    hold(1, 300); hold(0, 20);
    hold(1, 255); hold(0, 20);
    hold(1, 254); hold(0, 20);

    // R10: random lines with pseudo-syncs, width held between lines
    cur_req = "R10";
    for (int ln = 0; ln < 150; ln++) begin
      int pw, lw, ps;
      mask_en = ($urandom % 8) != 0;
      mask_en_width = 8'(4 + ($urandom % 40));
      pw = 5 + ($urandom % 30);
      lw = 200 + ($urandom % 100);
      ps = 1 + ($urandom % 3);
      hold(1, pw);
      for (int j = 0; j < ps; j++) begin
        hold(0, 1 + ($urandom % 4)); hold(1, 1 + ($urandom % 3));
      end
      hold(0, lw);
    end

    run_cmp = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule